// File: doc/BRIEF.md
# E1 CRC-4 Sub-Multiframe Monitor

This block sits on the receive side of an E1 link whose frame alignment and CRC multiframe alignment have already been found. It is fed one line bit per clock, together with the bit index inside the 256-bit frame and the frame number (0 to 15) inside the CRC multiframe. It splits the multiframe into two halves of eight frames, called sub-multiframes. It runs a 4-bit CRC over each half and compares that result with the four check bits that arrive in the following half.

Each mismatch produces a single-cycle error pulse and advances a saturating error counter. The mismatch is also queued for the far end. The two E-bit values handed to the local transmitter each carry one errored result, oldest first. They rest at 1 when nothing is pending. While the upstream alignment flag is low the block neither checks nor reports. It restarts cleanly at the next sub-multiframe boundary.

Top module: `e1_crc4_monitor`

## Requirements
- R1: After reset smfErr is 0, errCount is 0, and eBitFirst and eBitSecond are both 1.
- R2: The CRC of a sub-multiframe is the remainder of its 2048 bits (first received bit = highest power) times x^4, divided by x^4+x+1. The check-bit positions (bitPos 0 of frames with an even number) count as 0. Every other bit is covered, including bitPos 0 of odd frames. The check bits are taken from bitPos 0 of the even frames of the next sub-multiframe: frame 0/8 carries the most significant bit, then frame 2/10, then 4/12, then 6/14 (least significant). When they match, no pulse is produced.
- R3: On a mismatch, smfErr is high for exactly the one cycle after the last bit of the sub-multiframe that carried the check bits (frame 7 or 15, bitPos FRAME_BITS-1). It is low in every other cycle.
- R4: The first complete sub-multiframe after alignment is gained has no reference CRC and is never flagged, whatever its check bits hold.
- R5: errCount rises by one with each smfErr pulse and holds at its all-ones value.
- R6: The E-bits change only on the edge that ends bitPos FRAME_BITS-1 of frame 15. The new values come from the count of pending errored results, including one found on that same edge. eBitFirst (sent in frame 13) is 0 if at least one result is pending. eBitSecond (sent in frame 15) is 0 if at least two are pending. Each errored sub-multiframe clears exactly one E-bit, oldest first. With nothing pending both are 1.
- R7: One cycle after alignValid is low, both E-bits are 1 and the pending results are discarded. No pulse or count change occurs while alignValid is low. errCount keeps its value.
- R8: If alignValid rises in the middle of a sub-multiframe, that partial sub-multiframe is neither checked nor used as a reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBit | input | 1 | Received line bit for this cycle |
| bitPos | input | POS_W | Bit index in the frame, 0 = first bit of slot 0 |
| frameNum | input | 4 | Frame number inside the CRC multiframe |
| alignValid | input | 1 | Frame and CRC multiframe alignment held |
| smfErr | output | 1 | One-cycle pulse per errored sub-multiframe |
| errCount | output | CNT_W | Saturating errored sub-multiframe count |
| eBitFirst | output | 1 | E-bit value for frame 13 of the outgoing multiframe |
| eBitSecond | output | 1 | E-bit value for frame 15 of the outgoing multiframe |

## Verification
The bench checks several edge cases. A corrupted check bit in the very first sub-multiframe must be ignored; a design that compared against an empty reference would pulse there. Two errors in one multiframe must clear both E-bits; a design that merged results or dropped the one found on the frame-15 edge would leave one E-bit at 1 or report it a multiframe late. A corrupted bit at an odd-frame bitPos 0 position must still be caught, which exposes a design that masked all of bit 1. An alignment drop with an error pending, followed by a mid-sub-multiframe restart, must produce no report and no stale E-bit; a design that kept its queue or trusted the partial CRC would fail this. A narrow-counter instance on the same stream confirms that the counter holds at its ceiling.

// File: rtl/e1_crc4_pkg.sv
package e1_crc4_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic       clear;    // alignment absent: drop state
    logic       accum;    // bit belongs to a tracked sub-multiframe
    logic       cSlot;    // bit is a check-bit position
    logic [1:0] cIdx;     // which check bit (0 = most significant)
    logic       smfEnd;   // last bit of a tracked sub-multiframe
    logic       compare;  // a reference CRC exists for this one
    logic       mfEnd;    // last bit of frame 15 while aligned
  } crcStrobe_t;

  localparam logic [3:0] CRC4_TAPS = 4'b0011;

  function automatic logic [3:0] crc4Step(input logic [3:0] r, input logic d);
    logic fb;
    fb = r[3] ^ d;
    return {r[2:0], 1'b0} ^ (fb ? CRC4_TAPS : 4'b0000);
  endfunction

endpackage

// File: rtl/e1_crc4_ctrl.sv
module e1_crc4_ctrl
  import e1_crc4_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             alignValid,
  input  logic [POS_W-1:0] bitPos,
  input  logic [3:0]       frameNum,
  output crcStrobe_t       strb
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic inSmf;
  logic prevValid;
  logic atStart;
  logic atEnd;
  logic live;

  always_comb begin
    atStart = alignValid && (bitPos == '0) && (frameNum[2:0] == 3'd0);
    atEnd   = alignValid && (bitPos == LAST_POS) && (frameNum[2:0] == 3'd7);
    live    = alignValid && (inSmf || atStart);

    strb.clear   = !alignValid;
    strb.accum   = live;
    strb.cSlot   = live && (bitPos == '0) && !frameNum[0];
    strb.cIdx    = frameNum[2:1];
    strb.smfEnd  = live && atEnd;
    strb.compare = live && atEnd && prevValid;
    strb.mfEnd   = atEnd && frameNum[3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSmf     <= 1'b0;
      prevValid <= 1'b0;
    end else if (!alignValid) begin
      inSmf     <= 1'b0;
      prevValid <= 1'b0;
    end else begin
      if (atStart) inSmf <= 1'b1;
      if (live && atEnd) prevValid <= 1'b1;
    end
  end

endmodule

// File: rtl/e1_crc4_datapath.sv
module e1_crc4_datapath
  import e1_crc4_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PEND_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  crcStrobe_t       strb,
  output logic             smfErr,
  output logic [CNT_W-1:0] errCount,
  output logic             eBitFirst,
  output logic             eBitSecond
);

  localparam logic [PEND_W:0]   PEND_MAX = (PEND_W+1)'((1 << PEND_W) - 1);
  localparam logic [PEND_W:0]   TWO      = (PEND_W+1)'(2);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};

  logic [3:0]        crcAcc;
  logic [3:0]        refCrc;
  logic [3:0]        rxCheck;
  logic [PEND_W-1:0] pend;

  logic              dIn;
  logic [3:0]        crcNext;
  logic              mismatch;
  logic [PEND_W:0]   avail;
  logic [PEND_W:0]   taken;
  logic [PEND_W:0]   left;
  logic [PEND_W:0]   keep;

  always_comb begin
    dIn      = strb.cSlot ? 1'b0 : rxBit;
    crcNext  = crc4Step(crcAcc, dIn);
    mismatch = strb.compare && (rxCheck != refCrc);
    avail    = {1'b0, pend} + {{PEND_W{1'b0}}, mismatch};
    taken    = (avail >= TWO) ? TWO : avail;
    left     = strb.mfEnd ? (avail - taken) : avail;
    keep     = (left > PEND_MAX) ? PEND_MAX : left;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc     <= '0;
      refCrc     <= '0;
      rxCheck    <= '0;
      pend       <= '0;
      smfErr     <= 1'b0;
      errCount   <= '0;
      eBitFirst  <= 1'b1;
      eBitSecond <= 1'b1;
    end else begin
      smfErr <= mismatch;
      if (mismatch && (errCount != CNT_MAX)) errCount <= errCount + 1'b1;

      if (strb.clear) begin
        crcAcc     <= '0;
        pend       <= '0;
        eBitFirst  <= 1'b1;
        eBitSecond <= 1'b1;
      end else begin
        if (strb.accum) crcAcc <= strb.smfEnd ? 4'b0000 : crcNext;
        if (strb.smfEnd) refCrc <= crcNext;
        if (strb.cSlot) rxCheck[2'd3 - strb.cIdx] <= rxBit;
        if (strb.mfEnd) begin
          eBitFirst  <= (avail == '0);
          eBitSecond <= (avail < TWO);
        end
        pend <= keep[PEND_W-1:0];
      end
    end
  end

endmodule

// File: rtl/e1_crc4_monitor.sv
module e1_crc4_monitor
  import e1_crc4_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS),
  parameter int CNT_W      = 16,
  parameter int PEND_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxBit,
  input  logic [POS_W-1:0] bitPos,
  input  logic [3:0]       frameNum,
  input  logic             alignValid,
  output logic             smfErr,
  output logic [CNT_W-1:0] errCount,
  output logic             eBitFirst,
  output logic             eBitSecond
);

  crcStrobe_t strb;

  e1_crc4_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .POS_W     (POS_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .alignValid(alignValid),
    .bitPos    (bitPos),
    .frameNum  (frameNum),
    .strb      (strb)
  );

  e1_crc4_datapath #(
    .CNT_W (CNT_W),
    .PEND_W(PEND_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxBit     (rxBit),
    .strb      (strb),
    .smfErr    (smfErr),
    .errCount  (errCount),
    .eBitFirst (eBitFirst),
    .eBitSecond(eBitSecond)
  );

endmodule

// File: rtl/e1_crc4_monitor_sva.sv
module e1_crc4_monitor_sva #(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS),
  parameter int CNT_W      = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [POS_W-1:0] bitPos,
  input logic [3:0]       frameNum,
  input logic             alignValid,
  input logic             smfErr,
  input logic [CNT_W-1:0] errCount,
  input logic             eBitFirst,
  input logic             eBitSecond
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  // R3: a pulse lasts one cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    smfErr |=> !smfErr);

  // R3: a pulse follows the last bit of a sub-multiframe
  a_r3_at_smf_end: assert property (@(posedge clk) disable iff (!rstN)
    smfErr |-> ($past(bitPos) == LAST_POS && $past(frameNum[2:0]) == 3'd7));

  // R5: counter moves only with a pulse
  a_r5_count_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !smfErr |-> $stable(errCount));

  // R5: counter steps by one unless at ceiling
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (smfErr && $past(errCount) != {CNT_W{1'b1}}) |-> errCount == $past(errCount) + 1'b1);

  // R7: nothing reported while unaligned
  a_r7_quiet_unaligned: assert property (@(posedge clk) disable iff (!rstN)
    !$past(alignValid) |-> (!smfErr && eBitFirst && eBitSecond));

  // R6: E-bits move only at multiframe end or alignment loss
  a_r6_ebit_timing: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(eBitFirst) || !$stable(eBitSecond)) |->
      (!$past(alignValid) || ($past(frameNum) == 4'd15 && $past(bitPos) == LAST_POS)));

  // R6: second E-bit never cleared ahead of the first
  a_r6_ebit_order: assert property (@(posedge clk) disable iff (!rstN)
    !eBitSecond |-> !eBitFirst);

endmodule

bind e1_crc4_monitor e1_crc4_monitor_sva #(
  .FRAME_BITS(FRAME_BITS),
  .POS_W     (POS_W),
  .CNT_W     (CNT_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .bitPos    (bitPos),
  .frameNum  (frameNum),
  .alignValid(alignValid),
  .smfErr    (smfErr),
  .errCount  (errCount),
  .eBitFirst (eBitFirst),
  .eBitSecond(eBitSecond)
);

// File: tb/e1_crc4_monitor_bench.sv
`timescale 1ns/1ps
module e1_crc4_monitor_bench;

  localparam int FRAME_BITS = 256;
  localparam int POS_W      = 8;
  localparam int SMF_BITS   = FRAME_BITS * 8;
  localparam int CNT_W      = 16;
  localparam int SAT_W      = 3;

  // entry: [7:4] check-bit flip, [3] data hit, [2] expected pulse, [1] eBitFirst, [0] eBitSecond
  localparam logic [7:0] VEC [14] = '{
    8'hF3, 8'h03, 8'h17, 8'h01, 8'h85, 8'h24, 8'h00,
    8'h45, 8'h09, 8'h05, 8'h01, 8'h0B, 8'h07, 8'h01
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rxBit = 1'b0;
  logic [POS_W-1:0] bitPos = '0;
  logic [3:0]       frameNum = '0;
  logic             alignValid = 1'b0;
  logic             smfErr, smfErrSat;
  logic [CNT_W-1:0] errCount;
  logic [SAT_W-1:0] errCountSat;
  logic             eBitFirst, eBitSecond, eFirstSat, eSecondSat;

  always #2.5 clk = ~clk;

  e1_crc4_monitor #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .CNT_W(CNT_W)) u_e1_crc4_monitor (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .bitPos(bitPos), .frameNum(frameNum),
    .alignValid(alignValid), .smfErr(smfErr), .errCount(errCount),
    .eBitFirst(eBitFirst), .eBitSecond(eBitSecond)
  );

  e1_crc4_monitor #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .CNT_W(SAT_W)) u_e1_crc4_monitor_sat (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .bitPos(bitPos), .frameNum(frameNum),
    .alignValid(alignValid), .smfErr(smfErrSat), .errCount(errCountSat),
    .eBitFirst(eFirstSat), .eBitSecond(eSecondSat)
  );

  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;
  logic [31:0] prng = 32'h1ACE5EED;
  logic        smfData [SMF_BITS];
  int          stray;
  logic        lastPulse;

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic nextBit();
    prng = prng ^ (prng << 13);
    prng = prng ^ (prng >> 17);
    prng = prng ^ (prng << 5);
    return prng[0];
  endfunction

  // long division of the block (check positions zeroed) times x^4 by 10011
  function automatic logic [3:0] benchCrc();
    logic [4:0] r = 5'b0;
    for (int i = 0; i < SMF_BITS + 4; i++) begin
      logic m;
      if (i >= SMF_BITS) m = 1'b0;
      else if ((i % FRAME_BITS) == 0 && ((i / FRAME_BITS) % 2) == 0) m = 1'b0;
      else m = smfData[i];
      r = {r[3:0], m};
      if (r[4]) r = r ^ 5'b10011;
    end
    return r[3:0];
  endfunction

  task automatic stepCycle(input logic b, input int pos, input int frm, input logic av);
    @(negedge clk);
    rxBit      = b;
    bitPos     = POS_W'(pos);
    frameNum   = 4'(frm);
    alignValid = av;
    @(posedge clk);
    #1;
    lastPulse = smfErr;
  endtask

  task automatic sendSmf(input int half, input int firstFrame, input logic [3:0] cBits,
                         input bit hit, output logic [3:0] crcOut);
    for (int i = 0; i < SMF_BITS; i++) smfData[i] = nextBit();
    crcOut = benchCrc();
    if (hit) smfData[5 * FRAME_BITS] = ~smfData[5 * FRAME_BITS];
    stray = 0;
    for (int f = firstFrame; f < 8; f++) begin
      for (int p = 0; p < FRAME_BITS; p++) begin
        logic b;
        b = (p == 0 && (f % 2) == 0) ? cBits[3 - f / 2] : smfData[f * FRAME_BITS + p];
        stepCycle(b, p, half * 8 + f, 1'b1);
        if (lastPulse && !(f == 7 && p == FRAME_BITS - 1)) stray++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R3 watchdog actual=150000 expected=fewer cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] prevCrc;
    logic [3:0] crcOut;

    // R1 reset state
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    checkEq("R1", "smfErr", smfErr, 0);
    checkEq("R1", "errCount", errCount, 0);
    checkEq("R1", "eBitFirst", eBitFirst, 1);
    checkEq("R1", "eBitSecond", eBitSecond, 1);

    // table walk
    prevCrc = 4'h0;
    for (int i = 0; i < 14; i++) begin
      logic [7:0] v;
      v = VEC[i];
      sendSmf(i % 2, 0, prevCrc ^ v[7:4], v[3], crcOut);
      checkEq("R3", $sformatf("stray pulses entry %0d", i), stray, 0);
      checkEq("R2 R3 R4", $sformatf("pulse entry %0d", i), lastPulse, v[2]);
      checkEq("R6", $sformatf("eBitFirst entry %0d", i), eBitFirst, v[1]);
      checkEq("R6", $sformatf("eBitSecond entry %0d", i), eBitSecond, v[0]);
      prevCrc = crcOut;
    end
    checkEq("R5", "errCount after table", errCount, 6);
    checkEq("R5", "narrow errCount after table", errCountSat, 6);

    // error pending, then alignment loss
    sendSmf(0, 0, prevCrc ^ 4'h3, 1'b0, crcOut);
    checkEq("R3", "pulse before drop", lastPulse, 1);
    checkEq("R5", "errCount before drop", errCount, 7);
    stray = 0;
    for (int c = 0; c < 300; c++) begin
      stepCycle(nextBit(), c % FRAME_BITS, (c / FRAME_BITS) % 16, 1'b0);
      if (lastPulse) stray++;
    end
    checkEq("R7", "pulses while unaligned", stray, 0);
    checkEq("R7", "eBitFirst unaligned", eBitFirst, 1);
    checkEq("R7", "eBitSecond unaligned", eBitSecond, 1);
    checkEq("R7", "errCount kept", errCount, 7);

    // R8: realign in frame 11 with junk check bits
    sendSmf(1, 3, 4'hA, 1'b0, crcOut);
    checkEq("R8", "partial stray", stray, 0);
    checkEq("R8", "partial pulse", lastPulse, 0);
    checkEq("R7", "eBitFirst after drop", eBitFirst, 1);
    checkEq("R7", "eBitSecond after drop", eBitSecond, 1);

    // R4: first full block after realign, junk check bits
    sendSmf(0, 0, 4'h5, 1'b0, crcOut);
    checkEq("R4", "first block pulse", lastPulse, 0);
    prevCrc = crcOut;

    sendSmf(1, 0, prevCrc ^ 4'h8, 1'b0, crcOut);
    checkEq("R3", "pulse after realign", lastPulse, 1);
    checkEq("R5", "errCount", errCount, 8);
    checkEq("R5", "narrow errCount saturated", errCountSat, 7);
    checkEq("R6", "eBitFirst after realign", eBitFirst, 0);
    checkEq("R6", "eBitSecond after realign", eBitSecond, 1);
    prevCrc = crcOut;

    sendSmf(0, 0, prevCrc, 1'b0, crcOut);
    checkEq("R2", "clean block pulse", lastPulse, 0);
    checkEq("R2", "clean block stray", stray, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule